// File: doc/BRIEF.md
# Interrupt Request and In-Service Arbiter

This block keeps three 256-bit state arrays for interrupt vectors: pending requests, vectors in service, and the trigger mode (level or edge) of each request. Interrupt sources post a vector with a level/edge flag on an input port. The block presents the best eligible pending vector to the processor side. When the processor accepts that vector, the vector moves from pending to in service and is pushed on a nesting stack.

A processor priority is formed from a software-written task priority and the vector on top of the nesting stack. Only pending vectors whose priority class (upper nibble) is strictly above the class of that processor priority are offered. An end-of-interrupt write retires the highest vector in service. When that vector was level-triggered, the block emits a one-cycle notification carrying the vector so that the source can be re-armed.

A small register port gives read access to every array word and to the processor priority, write access to the task priority and the enable bit, and the end-of-interrupt command. Register map (5-bit word address): 0 task priority, 1 processor priority (read only), 2 end-of-interrupt (write only, reads 0), 3 control (bit 0 enable, read/write; bit 1 sticky nesting-overflow flag, read only), 8..15 request words 0..7, 16..23 in-service words 0..7, 24..31 trigger-mode words 0..7.

Top module: `vec_prio_arbiter`

## Requirements
- R1: After reset all request, in-service and trigger-mode words read 0, task and processor priority read 0, control reads 0 (disabled), and `pend_valid` and `eoi_valid` are 0.
- R2: With the enable bit (control bit 0) set, a posted vector v sets bit v%32 of request word v/32 (address 8+v/32) one cycle later, and sets that bit of trigger-mode word v/32 (address 24+v/32) if `irq_level` is 1, clearing it if 0.
- R3: While the enable bit is 0, posted vectors leave the request and trigger-mode arrays unchanged.
- R4: `pend_valid` is 1 exactly when a request bit among vectors 32..255 is set and the highest such vector has class vector[7:4] strictly greater than processor priority[7:4]; `pend_vector` is then that vector. Vectors 0..31 are never presented.
- R5: An accept with `acc_vector` equal to the presented vector clears its request bit, sets its in-service bit and pushes it on the nesting stack; an accept naming any other vector, or with `pend_valid` low, changes nothing.
- R6: The processor priority equals the task priority when task priority[7:4] is greater than or equal to the class of the top stacked vector (0 when the stack is empty), and otherwise equals that class in bits 7:4 with bits 3:0 zero.
- R7: A task priority write stores only bits 7:0 of the data, and the processor priority read in the next cycle already reflects it.
- R8: An end-of-interrupt write clears the highest set in-service bit among vectors 32..255 and pops the stack; with no such bit set it changes nothing.
- R9: In the cycle after an end-of-interrupt write that retires vector v, `eoi_valid` is 1 with `eoi_vector` = v if the trigger-mode bit of v is set; otherwise `eoi_valid` stays 0.
- R10: An end-of-interrupt write and an accept in the same cycle both take effect, the end-of-interrupt acting on the in-service state from before the accept.
- R11: Fourteen nested accepts of classes 2 through 15 fit in the stack; the overflow flag (control bit 1 and `nest_ovf`) stays 0 and an accept is refused, setting that flag, only when the stack is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_valid | input | 1 | A source posts a vector this cycle |
| irq_vector | input | 8 | Posted vector number |
| irq_level | input | 1 | 1 for a level-triggered source, 0 for edge |
| pend_valid | output | 1 | An eligible pending vector is offered |
| pend_vector | output | 8 | The offered vector |
| acc_valid | input | 1 | Processor accepts a vector this cycle |
| acc_vector | input | 8 | Vector being accepted |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| eoi_valid | output | 1 | Level-triggered vector retired last cycle |
| eoi_vector | output | 8 | Vector retired |
| nest_ovf | output | 1 | Sticky nesting-stack overflow flag |

## Verification
On every cycle the assertions check that the offered vector is never below 32, that a disabled block leaves the request array untouched, that an accepted vector lands in service, that the nesting-stack depth always equals the number of in-service bits, and that the stack is neither popped when empty nor pushed when full. The ordering of the offered vector against the processor priority, the exact task and processor priority values, the choice of which vector an end-of-interrupt retires, and the level-only notification can only be shown by the bench's scenarios against its own model, including the fourteen-deep nesting and the same-cycle end-of-interrupt and accept.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // Register groups selected by the upper address bits.
  typedef enum logic [1:0] {
    GRP_CTL = 2'd0,
    GRP_REQ = 2'd1,
    GRP_ISR = 2'd2,
    GRP_TMR = 2'd3
  } reg_grp_e;

  // Word offsets inside the control group.
  localparam int unsigned OFS_TPR = 0;
  localparam int unsigned OFS_PPR = 1;
  localparam int unsigned OFS_EOI = 2;
  localparam int unsigned OFS_CTL = 3;

  localparam int unsigned CLS_W = 4;
endpackage

// File: rtl/arb_find_top.sv
// Highest set bit at or above LOW in a flat bit vector.
module arb_find_top #(
  parameter int N     = 256,
  parameter int LOW   = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     bits,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = LOW; i < N; i++) begin
      if (bits[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/arb_nest_stack.sv
// Stack of in-service vectors; pop then push when both arrive together.
module arb_nest_stack #(
  parameter int DEPTH = 16,
  parameter int VEC_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       pop,
  input  logic [VEC_W-1:0]           push_vec,
  output logic [VEC_W-1:0]           top_vec,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  logic [VEC_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] top_idx;

  assign top_idx = IDX_W'(cnt_q - CNT_W'(1));

  always_comb begin
    cnt_d  = cnt_q;
    wr_en  = 1'b0;
    wr_idx = '0;
    if (pop && push) begin
      wr_en  = 1'b1;
      wr_idx = top_idx;
    end else if (pop) begin
      cnt_d = cnt_q - CNT_W'(1);
    end else if (push) begin
      wr_en  = 1'b1;
      wr_idx = IDX_W'(cnt_q);
      cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= push_vec;
  end

  assign top_vec = (cnt_q == '0) ? '0 : mem_q[top_idx];
  assign count   = cnt_q;
  assign full    = (cnt_q == CNT_W'(DEPTH));

  assert_pop_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));
  assert_push_room_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> !full);
endmodule

// File: rtl/vec_prio_arbiter.sv
module vec_prio_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_VEC     = 256,
  parameter int WORD_W      = 32,
  parameter int STACK_DEPTH = 16,
  parameter int ADDR_W      = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       irq_valid,
  input  logic [$clog2(NUM_VEC)-1:0] irq_vector,
  input  logic                       irq_level,
  output logic                       pend_valid,
  output logic [$clog2(NUM_VEC)-1:0] pend_vector,
  input  logic                       acc_valid,
  input  logic [$clog2(NUM_VEC)-1:0] acc_vector,
  input  logic                       reg_we,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [WORD_W-1:0]          reg_wdata,
  output logic [WORD_W-1:0]          reg_rdata,
  output logic                       eoi_valid,
  output logic [$clog2(NUM_VEC)-1:0] eoi_vector,
  output logic                       nest_ovf
);
  localparam int VEC_W     = $clog2(NUM_VEC);
  localparam int NUM_WORDS = NUM_VEC / WORD_W;
  localparam int WSEL_W    = $clog2(NUM_WORDS);
  localparam int CNT_W     = $clog2(STACK_DEPTH + 1);
  localparam int SUB_W     = VEC_W - CLS_W;

  // State
  logic [NUM_VEC-1:0] req_q, req_d, isr_q, isr_d, tmr_q, tmr_d;
  logic [VEC_W-1:0]   tpr_q, tpr_d;
  logic               en_q, en_d, ovf_q, ovf_d;
  logic               eoi_v_q, eoi_v_d;
  logic [VEC_W-1:0]   eoi_vec_q, eoi_vec_d;
  logic               arr_en;

  // Derived
  logic               req_found, isr_found;
  logic [VEC_W-1:0]   req_idx, isr_idx, top_vec, ppr;
  logic [CNT_W-1:0]   stk_cnt;
  logic               stk_full;
  logic [CLS_W-1:0]   top_cls, tpr_cls;
  logic               eoi_wr, eoi_do, acc_hit, acc_do;
  logic [WSEL_W-1:0]  wsel;
  reg_grp_e           grp;
  logic               unused_wdata;

  arb_find_top #(.N(NUM_VEC), .LOW(WORD_W), .IDX_W(VEC_W)) u_req_top (
    .bits(req_q), .found(req_found), .idx(req_idx));
  arb_find_top #(.N(NUM_VEC), .LOW(WORD_W), .IDX_W(VEC_W)) u_isr_top (
    .bits(isr_q), .found(isr_found), .idx(isr_idx));

  arb_nest_stack #(.DEPTH(STACK_DEPTH), .VEC_W(VEC_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(acc_do), .pop(eoi_do),
    .push_vec(acc_vector), .top_vec(top_vec), .count(stk_cnt), .full(stk_full));

  // Processor priority from task priority and top in-service class
  assign top_cls = top_vec[VEC_W-1 -: CLS_W];
  assign tpr_cls = tpr_q[VEC_W-1 -: CLS_W];
  assign ppr     = (tpr_cls >= top_cls) ? tpr_q : {top_cls, {SUB_W{1'b0}}};

  assign pend_valid  = req_found && (req_idx[VEC_W-1 -: CLS_W] > ppr[VEC_W-1 -: CLS_W]);
  assign pend_vector = req_idx;

  // Events of this cycle
  assign wsel    = reg_addr[WSEL_W-1:0];
  assign grp     = reg_grp_e'(reg_addr[ADDR_W-1:WSEL_W]);
  assign eoi_wr  = reg_we && (grp == GRP_CTL) && (int'(wsel) == OFS_EOI);
  assign eoi_do  = eoi_wr && isr_found;
  assign acc_hit = acc_valid && pend_valid && (acc_vector == pend_vector);
  assign acc_do  = acc_hit && (!stk_full || eoi_do);
  assign arr_en  = eoi_do || acc_do || (irq_valid && en_q);

  always_comb begin
    req_d = req_q;
    isr_d = isr_q;
    tmr_d = tmr_q;
    if (eoi_do) isr_d[isr_idx] = 1'b0;
    if (acc_do) begin
      req_d[acc_vector] = 1'b0;
      isr_d[acc_vector] = 1'b1;
    end
    if (irq_valid && en_q) begin
      req_d[irq_vector] = 1'b1;
      tmr_d[irq_vector] = irq_level;
    end
  end

  always_comb begin
    tpr_d     = tpr_q;
    en_d      = en_q;
    ovf_d     = ovf_q || (acc_hit && !acc_do);
    eoi_v_d   = eoi_do && tmr_q[isr_idx];
    eoi_vec_d = eoi_do ? isr_idx : eoi_vec_q;
    if (reg_we && grp == GRP_CTL && int'(wsel) == OFS_TPR) tpr_d = reg_wdata[VEC_W-1:0];
    if (reg_we && grp == GRP_CTL && int'(wsel) == OFS_CTL) en_d = reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      isr_q <= '0;
      tmr_q <= '0;
    end else if (arr_en) begin
      req_q <= req_d;
      isr_q <= isr_d;
      tmr_q <= tmr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tpr_q     <= '0;
      en_q      <= 1'b0;
      ovf_q     <= 1'b0;
      eoi_v_q   <= 1'b0;
      eoi_vec_q <= '0;
    end else begin
      tpr_q     <= tpr_d;
      en_q      <= en_d;
      ovf_q     <= ovf_d;
      eoi_v_q   <= eoi_v_d;
      eoi_vec_q <= eoi_vec_d;
    end
  end

  assign eoi_valid  = eoi_v_q;
  assign eoi_vector = eoi_vec_q;
  assign nest_ovf   = ovf_q;

  // Register read path
  always_comb begin
    reg_rdata = '0;
    unique case (grp)
      GRP_CTL: begin
        if (int'(wsel) == OFS_TPR) reg_rdata = WORD_W'(tpr_q);
        if (int'(wsel) == OFS_PPR) reg_rdata = WORD_W'(ppr);
        if (int'(wsel) == OFS_CTL) reg_rdata = WORD_W'({ovf_q, en_q});
      end
      GRP_REQ: reg_rdata = req_q[int'(wsel)*WORD_W +: WORD_W];
      GRP_ISR: reg_rdata = isr_q[int'(wsel)*WORD_W +: WORD_W];
      GRP_TMR: reg_rdata = tmr_q[int'(wsel)*WORD_W +: WORD_W];
      default: reg_rdata = '0;
    endcase
  end

  assign unused_wdata = ^reg_wdata[WORD_W-1:VEC_W];

  // Assertions
  assert_pend_above_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> (int'(pend_vector) >= WORD_W));
  assert_disabled_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !acc_do) |=> $stable(req_q));
  assert_accept_in_service_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_do |=> isr_q[$past(acc_vector)]);
  assert_stack_tracks_isr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(stk_cnt) == $countones(isr_q));
  assert_eoi_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> $past(eoi_wr));
endmodule

// File: tb/vec_prio_arbiter_bench.sv
module vec_prio_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        irq_valid, irq_level, acc_valid, reg_we;
  logic [7:0]  irq_vector, acc_vector;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        pend_valid, eoi_valid, nest_ovf;
  logic [7:0]  pend_vector, eoi_vector;

  int checks = 0;
  int fails  = 0;

  // Bench model
  logic [255:0] m_req, m_isr, m_tmr;
  logic [7:0]   m_tpr;
  logic         m_en, m_ovf, m_eoi_v;
  logic [7:0]   m_eoi_vec;
  logic [7:0]   m_stk [DEPTH];
  int           m_sp;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_prio_arbiter u_vec_prio_arbiter (
    .clk(clk), .rst_n(rst_n),
    .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_level(irq_level),
    .pend_valid(pend_valid), .pend_vector(pend_vector),
    .acc_valid(acc_valid), .acc_vector(acc_vector),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .nest_ovf(nest_ovf));

  function automatic logic [7:0] f_ppr();
    logic [7:0] top;
    top = (m_sp == 0) ? 8'h00 : m_stk[m_sp-1];
    if (m_tpr[7:4] >= top[7:4]) return m_tpr;
    return {top[7:4], 4'h0};
  endfunction

  function automatic logic [8:0] f_pend();
    logic       found;
    logic [7:0] best, p;
    found = 1'b0;
    best  = 8'h00;
    for (int v = 32; v < 256; v++) if (m_req[v]) begin found = 1'b1; best = 8'(v); end
    p = f_ppr();
    return {found && (best[7:4] > p[7:4]), best};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic check_all(input string tag);
    rd(5'd0, {24'h0, m_tpr}, {tag, " tpr"});
    rd(5'd1, {24'h0, f_ppr()}, {tag, " ppr R6"});
    rd(5'd3, {30'h0, m_ovf, m_en}, {tag, " ctl"});
    for (int w = 0; w < 8; w++) begin
      rd(5'(8 + w),  m_req[w*32 +: 32], {tag, " req R2"});
      rd(5'(16 + w), m_isr[w*32 +: 32], {tag, " isr R8"});
      rd(5'(24 + w), m_tmr[w*32 +: 32], {tag, " tmr R2"});
    end
  endtask

  task automatic step(input logic iv, input logic [7:0] ivec, input logic il,
                      input logic av, input logic [7:0] avec,
                      input logic we, input logic [4:0] ad, input logic [31:0] wd);
    logic [8:0] pd;
    logic [7:0] h;
    logic       hf;
    @(negedge clk);
    irq_valid = iv; irq_vector = ivec; irq_level = il;
    acc_valid = av; acc_vector = avec;
    reg_we = we; reg_addr = ad; reg_wdata = wd;
    pd = f_pend();
    @(posedge clk);
    #1;
    m_eoi_v = 1'b0;
    hf = 1'b0;
    h  = 8'h00;
    for (int v = 32; v < 256; v++) if (m_isr[v]) begin hf = 1'b1; h = 8'(v); end
    if (we && ad == 5'd2 && hf) begin
      m_isr[h]  = 1'b0;
      m_sp--;
      m_eoi_v   = m_tmr[h];
      m_eoi_vec = h;
    end
    if (av && pd[8] && avec == pd[7:0]) begin
      if (m_sp < DEPTH) begin
        m_stk[m_sp] = avec;
        m_sp++;
        m_req[avec] = 1'b0;
        m_isr[avec] = 1'b1;
      end else m_ovf = 1'b1;
    end
    if (iv && m_en) begin
      m_req[ivec] = 1'b1;
      m_tmr[ivec] = il;
    end
    if (we && ad == 5'd0) m_tpr = wd[7:0];
    if (we && ad == 5'd3) m_en  = wd[0];
    irq_valid = 1'b0; acc_valid = 1'b0; reg_we = 1'b0;
    chk("R9 eoi_valid", {31'h0, eoi_valid}, {31'h0, m_eoi_v});
    if (m_eoi_v) chk("R9 eoi_vector", {24'h0, eoi_vector}, {24'h0, m_eoi_vec});
    pd = f_pend();
    chk("R4 pend_valid", {31'h0, pend_valid}, {31'h0, pd[8]});
    if (pd[8]) chk("R4 pend_vector", {24'h0, pend_vector}, {24'h0, pd[7:0]});
  endtask

  task automatic idle();
    step(1'b0, 8'h0, 1'b0, 1'b0, 8'h0, 1'b0, 5'd0, 32'h0);
  endtask
  task automatic post(input logic [7:0] v, input logic lvl);
    step(1'b1, v, lvl, 1'b0, 8'h0, 1'b0, 5'd0, 32'h0);
  endtask
  task automatic accept(input logic [7:0] v);
    step(1'b0, 8'h0, 1'b0, 1'b1, v, 1'b0, 5'd0, 32'h0);
  endtask
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    step(1'b0, 8'h0, 1'b0, 1'b0, 8'h0, 1'b1, a, d);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [7:0]  av;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0;
    irq_valid = 1'b0; irq_vector = '0; irq_level = 1'b0;
    acc_valid = 1'b0; acc_vector = '0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    m_req = '0; m_isr = '0; m_tmr = '0; m_tpr = '0;
    m_en = 1'b0; m_ovf = 1'b0; m_eoi_v = 1'b0; m_eoi_vec = '0; m_sp = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check_all("R1");
    chk("R1 pend_valid", {31'h0, pend_valid}, 32'h0);
    chk("R1 eoi_valid", {31'h0, eoi_valid}, 32'h0);

    // R3 disabled block ignores posts
    post(8'd100, 1'b1);
    rd(5'd11, 32'h0, "R3 req word3");
    rd(5'd27, 32'h0, "R3 tmr word3");

    // R2 arrival
    wr(5'd3, 32'h1);
    post(8'h45, 1'b0);
    post(8'h20, 1'b1);
    post(8'h10, 1'b0);
    rd(5'd10, 32'h0000_0020, "R2 req word2");
    rd(5'd9,  32'h0000_0001, "R2 req word1");
    rd(5'd8,  32'h0001_0000, "R2 req word0");
    rd(5'd25, 32'h0000_0001, "R2 level tmr");
    rd(5'd26, 32'h0, "R2 edge tmr");
    chk("R4 highest offered", {24'h0, pend_vector}, 32'h45);

    // R5 wrong accept ignored, right accept moves vector
    accept(8'h20);
    rd(5'd17, 32'h0, "R5 wrong accept isr");
    rd(5'd9, 32'h1, "R5 wrong accept req");
    accept(8'h45);
    rd(5'd18, 32'h0000_0020, "R5 isr set");
    rd(5'd10, 32'h0, "R5 req cleared");
    rd(5'd1, 32'h40, "R6 ppr from in-service");
    chk("R6 lower class blocked", {31'h0, pend_valid}, 32'h0);

    // R7 / R6 task priority
    wr(5'd0, 32'h0000_01F3);
    rd(5'd0, 32'hF3, "R7 tpr low byte");
    rd(5'd1, 32'hF3, "R7 ppr follows");
    wr(5'd0, 32'h4A);
    rd(5'd1, 32'h4A, "R6 equal class takes tpr");
    wr(5'd0, 32'h35);
    rd(5'd1, 32'h40, "R6 lower tpr class");
    wr(5'd0, 32'h0);

    // R8 / R9 end of interrupt
    wr(5'd2, 32'h0);
    chk("R9 edge no notify", {31'h0, eoi_valid}, 32'h0);
    rd(5'd18, 32'h0, "R8 isr cleared");
    accept(8'h20);
    wr(5'd2, 32'h0);
    chk("R9 level notify", {31'h0, eoi_valid}, 32'h1);
    chk("R9 level vector", {24'h0, eoi_vector}, 32'h20);
    wr(5'd2, 32'h0);
    chk("R8 empty eoi no notify", {31'h0, eoi_valid}, 32'h0);
    check_all("R8 empty eoi");

    // R10 same-cycle end of interrupt and accept
    post(8'h30, 1'b0);
    accept(8'h30);
    post(8'h90, 1'b0);
    step(1'b0, 8'h0, 1'b0, 1'b1, 8'h90, 1'b1, 5'd2, 32'h0);
    rd(5'd17, 32'h0, "R10 old retired");
    rd(5'd20, 32'h0001_0000, "R10 new in service");
    rd(5'd1, 32'h90, "R10 ppr");
    wr(5'd2, 32'h0);

    // R11 fourteen nested levels
    for (int c = 2; c < 16; c++) begin
      post({4'(c), 4'hF}, c[0]);
      accept({4'(c), 4'hF});
    end
    rd(5'd3, 32'h1, "R11 no overflow");
    chk("R11 nest_ovf", {31'h0, nest_ovf}, 32'h0);
    rd(5'd1, 32'hF0, "R11 ppr top class");
    check_all("R11 nested");
    for (int c = 0; c < 14; c++) wr(5'd2, 32'h0);
    check_all("R11 unwound");

    // Random phase
    for (int n = 0; n < 3000; n++) begin
      r  = $urandom;
      av = (r[6:4] == 3'd0) ? (pend_vector ^ 8'h01) : pend_vector;
      if (r[11:8] < 4'd3)
        step(r[0] | r[1], 8'($urandom_range(0, 255)), r[2], r[3] & pend_valid, av,
             1'b1, 5'd2, 32'h0);
      else if (r[11:8] == 4'd3)
        step(r[0] | r[1], 8'($urandom_range(0, 255)), r[2], r[3] & pend_valid, av,
             1'b1, 5'd0, 32'($urandom_range(0, 160)));
      else if (r[15:12] == 4'd0)
        step(r[0] | r[1], 8'($urandom_range(0, 255)), r[2], r[3] & pend_valid, av,
             1'b1, 5'd3, {31'h0, r[16] | r[17]});
      else
        step(r[0] | r[1], 8'($urandom_range(0, 255)), r[2], r[3] & pend_valid, av,
             1'b0, 5'd0, 32'h0);
      if (n % 500 == 499) check_all("R2 R5 R8 random");
    end
    chk("R11 no overflow random", {31'h0, nest_ovf}, {31'h0, m_ovf});
    idle();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule